// File: doc/BRIEF.md
# Burst-Aligned Host Memory DMA Engine

This engine sits on the accelerator side of a host link and moves blocks of data between host memory and local user circuits on its own initiative. A command supplies a byte address, a byte length and a direction. For the host-to-user direction the engine issues read requests and forwards the returned 64-bit words to a streaming output. For the user-to-host direction it collects words from a streaming input and issues write requests that carry data and per-byte enables.

Every request burst stays inside one 64-byte block of host memory. A transfer whose start or end falls inside a block produces shorter partial bursts at that end. The read channel and the write channel have separate state, so one transfer of each kind can be in progress at the same time. Outgoing write data passes through two burst-sized buffer halves: user logic fills one half while the other half drains to the host.

Top module: `hostdma_engine`

## Requirements
- R1: A command is accepted when `cmd_valid` is high, `cmd_len` is non-zero and the channel chosen by `cmd_dir` is idle (0 selects host-to-user reads, 1 selects user-to-host writes). In the next cycle that channel's bit of `busy` is high and its bit of `done` is low.
- R2: While a channel is busy, a command for that channel has no effect. The running transfer keeps its addresses and word count, and no second transfer follows it.
- R3: The first read burst covers min(len, 64 − addr mod 64) bytes and each later burst covers min(remaining, 64) bytes. `rd_req_addr` is the burst's byte address rounded down to a multiple of 8. `rd_req_words` is the number of 64-bit words the burst touches. No burst crosses a 64-byte boundary.
- R4: Each returned read word appears on `usr_out_data` with `usr_out_valid` in the same cycle, unchanged.
- R5: A read transfer ends only after all bursts have been requested and as many words have returned as were requested. The engine then sets `done[0]`, drops `busy[0]` and raises `done_pulse[0]` for exactly one cycle.
- R6: For writes, user words are taken whenever `usr_in_valid` and `usr_in_ready` are both high. They are written in bursts that follow the splitting of R3. Each word carries its own word address in `wr_req_addr`, and `wr_req_last` marks the final word of each burst.
- R7: Bit b of `wr_req_be` enables byte lane b (data bits 8b+7..8b). A lane is enabled exactly when its byte address lies inside [addr, addr+len). Only the first and last words of a transfer can be partial.
- R8: Write data is double-buffered. While the first burst waits for `wr_req_ready`, the user can fill a second burst. Once both halves are full, `usr_in_ready` stays low.
- R9: A write transfer ends once every word has been accepted by the host side. The engine then sets `done[1]`, drops `busy[1]` and raises `done_pulse[1]` for one cycle.
- R10: A read transfer and a write transfer can run at the same time, and both complete.
- R11: A request held back by a low ready keeps its valid, address and contents unchanged until it is accepted.
- R12: While reset is active, `busy`, `done`, `done_pulse`, `rd_req_valid`, `wr_req_valid` and `usr_in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_dir | input | 1 | 0 host-to-user read, 1 user-to-host write |
| cmd_addr | input | ADDR_W | Host byte address |
| cmd_len | input | LEN_W | Length in bytes |
| busy | output | 2 | Per channel (bit 0 read, bit 1 write) transfer in progress |
| done | output | 2 | Per channel last transfer finished |
| done_pulse | output | 2 | Per channel one-cycle completion strobe |
| rd_req_valid | output | 1 | Read burst request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Word-aligned burst address |
| rd_req_words | output | WC_W | Words in the read burst |
| rd_rsp_valid | input | 1 | Returned read word valid |
| rd_rsp_data | input | 64 | Returned read word |
| usr_out_valid | output | 1 | Word to user logic valid |
| usr_out_data | output | 64 | Word to user logic |
| usr_in_valid | input | 1 | Word from user logic valid |
| usr_in_ready | output | 1 | Engine can take a user word |
| usr_in_data | input | 64 | Word from user logic |
| wr_req_valid | output | 1 | Write word request |
| wr_req_ready | input | 1 | Write word accepted |
| wr_req_addr | output | ADDR_W | Word address of this write word |
| wr_req_data | output | 64 | Write data |
| wr_req_be | output | 8 | Byte enables |
| wr_req_last | output | 1 | Final word of the burst |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit lengths and 64-byte bursts. With these values a few hundred bytes already span several bursts, and vectors that start one byte below a block boundary, start mid-word or end mid-word exercise the partial first and last bursts and their byte enables. Stalling the host-side ready lines brings the double buffer to its full state and shows requests being held.

// File: rtl/hostdma_pkg.sv
package hostdma_pkg;
  localparam int DATA_W     = 64;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LB         = $clog2(WORD_BYTES);

  typedef enum logic {
    DIR_H2U = 1'b0,
    DIR_U2H = 1'b1
  } dir_e;
endpackage

// File: rtl/hostdma_burst_plan.sv
module hostdma_burst_plan
  import hostdma_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 64,
  parameter int OFF_W       = $clog2(BURST_BYTES),
  parameter int BB_W        = OFF_W + 1,
  parameter int WC_W        = $clog2(BURST_BYTES / WORD_BYTES) + 1
) (
  input  logic [OFF_W-1:0] addr_lo,
  input  logic [LEN_W-1:0] rem,
  output logic [BB_W-1:0]  bytes,
  output logic [WC_W-1:0]  words
);
  logic [BB_W-1:0] room;
  logic [BB_W:0]   span;

  always_comb begin
    room = BB_W'(BURST_BYTES) - BB_W'(addr_lo);
    if ({1'b0, rem} < (LEN_W+1)'(room)) bytes = BB_W'(rem);
    else                                bytes = room;
    span  = (BB_W+1)'(addr_lo[LB-1:0]) + (BB_W+1)'(bytes) + (BB_W+1)'(WORD_BYTES - 1);
    words = WC_W'(span >> LB);
  end
endmodule

// File: rtl/hostdma_rd_chan.sv
module hostdma_rd_chan
  import hostdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 64,
  parameter int OFF_W       = $clog2(BURST_BYTES),
  parameter int BB_W        = OFF_W + 1,
  parameter int WC_W        = $clog2(BURST_BYTES / WORD_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LEN_W-1:0]  st_len,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WC_W-1:0]   req_words,
  input  logic              rsp_valid,
  output logic              busy,
  output logic              done,
  output logic              done_pulse
);
  localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;

  logic              act_q, act_d, done_q, done_d, pulse_q, pulse_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d, outst_q, outst_d;
  logic [BB_W-1:0]   b_bytes;
  logic              req_fire;

  hostdma_burst_plan #(.LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) u_plan (
    .addr_lo(addr_q[OFF_W-1:0]), .rem(rem_q), .bytes(b_bytes), .words(req_words)
  );

  assign req_valid  = act_q && (rem_q != '0);
  assign req_addr   = {addr_q[ADDR_W-1:LB], LB'(0)};
  assign req_fire   = req_valid && req_ready;
  assign busy       = act_q;
  assign done       = done_q;
  assign done_pulse = pulse_q;

  always_comb begin
    act_d   = act_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    outst_d = outst_q;
    done_d  = done_q;
    pulse_d = 1'b0;
    if (start) begin
      act_d   = 1'b1;
      addr_d  = st_addr;
      rem_d   = st_len;
      outst_d = '0;
      done_d  = 1'b0;
    end else if (act_q) begin
      if (req_fire) begin
        addr_d = addr_q + ADDR_W'(b_bytes);
        rem_d  = rem_q - LEN_W'(b_bytes);
      end
      outst_d = outst_q + (req_fire ? LEN_W'(req_words) : '0)
                        - (rsp_valid ? LEN_W'(1) : '0);
      if ((rem_q == '0) && (outst_q == '0)) begin
        act_d   = 1'b0;
        done_d  = 1'b1;
        pulse_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      outst_q <= '0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      outst_q <= outst_d;
      done_q  <= done_d;
      pulse_q <= pulse_d;
    end
  end

  assert_rd_in_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_addr[OFF_W-1:LB]) + int'(req_words)) <= BURST_WORDS);
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_words));
  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done && !busy);
  assert_rd_pulse_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

// File: rtl/hostdma_wr_chan.sv
module hostdma_wr_chan
  import hostdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 64,
  parameter int OFF_W       = $clog2(BURST_BYTES),
  parameter int BB_W        = OFF_W + 1,
  parameter int WC_W        = $clog2(BURST_BYTES / WORD_BYTES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [LEN_W-1:0]      st_len,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [DATA_W-1:0]     req_data,
  output logic [WORD_BYTES-1:0] req_be,
  output logic                  req_last,
  output logic                  busy,
  output logic                  done,
  output logic                  done_pulse
);
  localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;
  localparam int WI_W        = $clog2(BURST_WORDS);

  // two burst-sized halves and the burst each holds
  logic [DATA_W-1:0] buf_q   [2][BURST_WORDS];
  logic [ADDR_W-1:0] base_q  [2];
  logic [LB-1:0]     off_q   [2];
  logic [BB_W-1:0]   bytes_q [2];
  logic [WC_W-1:0]   words_q [2];

  logic              act_q, act_d, done_q, done_d, pulse_q, pulse_d;
  logic              filling_q, filling_d, fsel_q, fsel_d, dsel_q, dsel_d;
  logic [1:0]        full_q, full_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [LEN_W-1:0]  frem_q, frem_d;
  logic [WI_W-1:0]   fcnt_q, fcnt_d, dcnt_q, dcnt_d;
  logic [BB_W-1:0]   p_bytes;
  logic [WC_W-1:0]   p_words;
  logic              start_fill, in_fire, fill_end, req_fire;
  logic [BB_W:0]     pos, lo, hi;

  hostdma_burst_plan #(.LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) u_plan (
    .addr_lo(faddr_q[OFF_W-1:0]), .rem(frem_q), .bytes(p_bytes), .words(p_words)
  );

  assign start_fill = act_q && !filling_q && (frem_q != '0) && !full_q[fsel_q];
  assign in_ready   = filling_q;
  assign in_fire    = filling_q && in_valid;
  assign fill_end   = in_fire && ((WC_W'(fcnt_q) + WC_W'(1)) == words_q[fsel_q]);
  assign req_valid  = full_q[dsel_q];
  assign req_last   = (WC_W'(dcnt_q) + WC_W'(1)) == words_q[dsel_q];
  assign req_fire   = req_valid && req_ready;
  assign req_addr   = base_q[dsel_q] + (ADDR_W'(dcnt_q) << LB);
  assign req_data   = buf_q[dsel_q][dcnt_q];
  assign busy       = act_q;
  assign done       = done_q;
  assign done_pulse = pulse_q;

  always_comb begin
    lo = (BB_W+1)'(off_q[dsel_q]);
    hi = lo + (BB_W+1)'(bytes_q[dsel_q]);
    pos = '0;
    for (int b = 0; b < WORD_BYTES; b++) begin
      pos       = (BB_W+1)'({dcnt_q, LB'(b)});
      req_be[b] = (pos >= lo) && (pos < hi);
    end
  end

  always_comb begin
    act_d     = act_q;
    done_d    = done_q;
    pulse_d   = 1'b0;
    filling_d = filling_q;
    fsel_d    = fsel_q;
    dsel_d    = dsel_q;
    full_d    = full_q;
    faddr_d   = faddr_q;
    frem_d    = frem_q;
    fcnt_d    = fcnt_q;
    dcnt_d    = dcnt_q;
    if (start) begin
      act_d   = 1'b1;
      done_d  = 1'b0;
      faddr_d = st_addr;
      frem_d  = st_len;
    end
    if (start_fill) begin
      faddr_d   = faddr_q + ADDR_W'(p_bytes);
      frem_d    = frem_q - LEN_W'(p_bytes);
      filling_d = 1'b1;
      fcnt_d    = '0;
    end
    if (in_fire) begin
      fcnt_d = fcnt_q + WI_W'(1);
      if (fill_end) begin
        filling_d      = 1'b0;
        full_d[fsel_q] = 1'b1;
        fsel_d         = ~fsel_q;
      end
    end
    if (req_fire) begin
      dcnt_d = dcnt_q + WI_W'(1);
      if (req_last) begin
        dcnt_d         = '0;
        full_d[dsel_q] = 1'b0;
        dsel_d         = ~dsel_q;
      end
    end
    if (act_q && (frem_q == '0) && !filling_q && (full_q == 2'b00)) begin
      act_d   = 1'b0;
      done_d  = 1'b1;
      pulse_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      done_q    <= 1'b0;
      pulse_q   <= 1'b0;
      filling_q <= 1'b0;
      fsel_q    <= 1'b0;
      dsel_q    <= 1'b0;
      full_q    <= 2'b00;
      faddr_q   <= '0;
      frem_q    <= '0;
      fcnt_q    <= '0;
      dcnt_q    <= '0;
    end else begin
      act_q     <= act_d;
      done_q    <= done_d;
      pulse_q   <= pulse_d;
      filling_q <= filling_d;
      fsel_q    <= fsel_d;
      dsel_q    <= dsel_d;
      full_q    <= full_d;
      faddr_q   <= faddr_d;
      frem_q    <= frem_d;
      fcnt_q    <= fcnt_d;
      dcnt_q    <= dcnt_d;
    end
  end

  // storage without reset, written under explicit enables
  always_ff @(posedge clk) begin
    if (start_fill) begin
      base_q[fsel_q]  <= {faddr_q[ADDR_W-1:LB], LB'(0)};
      off_q[fsel_q]   <= faddr_q[LB-1:0];
      bytes_q[fsel_q] <= p_bytes;
      words_q[fsel_q] <= p_words;
    end
    if (in_fire) buf_q[fsel_q][fcnt_q] <= in_data;
  end

  assert_wr_be_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_be != '0);
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)
                                && $stable(req_be) && $stable(req_last));
  assert_in_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
  assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done && !busy);
endmodule

// File: rtl/hostdma_engine.sv
module hostdma_engine
  import hostdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 64,
  localparam int WC_W       = $clog2(BURST_BYTES / WORD_BYTES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_dir,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [LEN_W-1:0]      cmd_len,
  output logic [1:0]            busy,
  output logic [1:0]            done,
  output logic [1:0]            done_pulse,
  output logic                  rd_req_valid,
  input  logic                  rd_req_ready,
  output logic [ADDR_W-1:0]     rd_req_addr,
  output logic [WC_W-1:0]       rd_req_words,
  input  logic                  rd_rsp_valid,
  input  logic [DATA_W-1:0]     rd_rsp_data,
  output logic                  usr_out_valid,
  output logic [DATA_W-1:0]     usr_out_data,
  input  logic                  usr_in_valid,
  output logic                  usr_in_ready,
  input  logic [DATA_W-1:0]     usr_in_data,
  output logic                  wr_req_valid,
  input  logic                  wr_req_ready,
  output logic [ADDR_W-1:0]     wr_req_addr,
  output logic [DATA_W-1:0]     wr_req_data,
  output logic [WORD_BYTES-1:0] wr_req_be,
  output logic                  wr_req_last
);
  logic [1:0] rst_pipe;
  logic       rst_s, cmd_ok, rd_start, wr_start;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign cmd_ok   = cmd_valid && (cmd_len != '0);
  assign rd_start = cmd_ok && (cmd_dir == DIR_H2U) && !busy[0];
  assign wr_start = cmd_ok && (cmd_dir == DIR_U2H) && !busy[1];

  assign usr_out_valid = rd_rsp_valid;
  assign usr_out_data  = rd_rsp_data;

  hostdma_rd_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_s), .start(rd_start), .st_addr(cmd_addr), .st_len(cmd_len),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .req_words(rd_req_words), .rsp_valid(rd_rsp_valid),
    .busy(busy[0]), .done(done[0]), .done_pulse(done_pulse[0])
  );

  hostdma_wr_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) u_wr (
    .clk(clk), .rst_n(rst_s), .start(wr_start), .st_addr(cmd_addr), .st_len(cmd_len),
    .in_valid(usr_in_valid), .in_ready(usr_in_ready), .in_data(usr_in_data),
    .req_valid(wr_req_valid), .req_ready(wr_req_ready), .req_addr(wr_req_addr),
    .req_data(wr_req_data), .req_be(wr_req_be), .req_last(wr_req_last),
    .busy(busy[1]), .done(done[1]), .done_pulse(done_pulse[1])
  );

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_s)
    rd_start |=> busy[0] && !done[0]);
  assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (busy & done) == 2'b00);
  assert_cmd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_s)
    busy[0] && cmd_valid && (cmd_dir == DIR_H2U) |=> busy[0] || done[0]);
endmodule

// File: tb/hostdma_engine_test.sv
`timescale 1ns/1ps
module hostdma_engine_test;
  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic [7:0]  bursts;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{32'h0000_1000, 16'd64,  8'd1},
    '{32'h0000_1010, 16'd64,  8'd2},
    '{32'h0000_1003, 16'd10,  8'd1},
    '{32'h0000_203C, 16'd200, 8'd5},
    '{32'h0000_3000, 16'd1,   8'd1},
    '{32'h0000_3FFF, 16'd2,   8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_dir;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;
  logic [1:0]  busy, done, done_pulse;
  logic        rd_req_valid, rd_req_ready;
  logic [31:0] rd_req_addr;
  logic [3:0]  rd_req_words;
  logic        rd_rsp_valid;
  logic [63:0] rd_rsp_data;
  logic        usr_out_valid;
  logic [63:0] usr_out_data;
  logic        usr_in_valid, usr_in_ready;
  logic [63:0] usr_in_data;
  logic        wr_req_valid, wr_req_ready;
  logic [31:0] wr_req_addr;
  logic [63:0] wr_req_data;
  logic [7:0]  wr_req_be;
  logic        wr_req_last;

  hostdma_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .busy(busy), .done(done),
    .done_pulse(done_pulse), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_words(rd_req_words), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .usr_out_valid(usr_out_valid), .usr_out_data(usr_out_data),
    .usr_in_valid(usr_in_valid), .usr_in_ready(usr_in_ready), .usr_in_data(usr_in_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
    .wr_req_data(wr_req_data), .wr_req_be(wr_req_be), .wr_req_last(wr_req_last)
  );

  initial forever #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  // host and user models' state
  logic [31:0] r_exp_addr, cur_rsp;
  logic [31:0] pend [0:255];
  int          p_wr = 0, p_rd = 0, r_bursts, r_words;
  bit          r_ready_en = 1'b1, w_ready_en = 1'b1, u_en = 1'b0;
  logic [31:0] w_exp_addr, w_base, w_lo, w_hi;
  int          w_bursts, w_words, u_fed, u_total;
  int          dp_cnt [2];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rpat(input logic [31:0] a);
    return {a, a ^ 32'h5A5A_5A5A};
  endfunction

  function automatic logic [63:0] upat(input int k);
    return 64'hC0DE_0000_0000_0000 + 64'(k);
  endfunction

  function automatic logic [7:0] exp_be(input logic [31:0] wa);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((wa + 32'(b)) >= w_lo) && ((wa + 32'(b)) < w_hi);
    return m;
  endfunction

  function automatic int tot_words(input logic [31:0] a, input logic [15:0] l);
    return (int'(a[2:0]) + int'(l) + 7) / 8;
  endfunction

  // host link and user stream models, all driven at the falling edge
  initial begin
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    wr_req_ready = 1'b0; usr_in_valid = 1'b0; usr_in_data = '0;
    forever begin
      @(negedge clk);
      if (done_pulse[0]) dp_cnt[0]++;
      if (done_pulse[1]) dp_cnt[1]++;
      if (p_rd != p_wr) begin
        cur_rsp      = pend[p_rd % 256];
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = rpat(cur_rsp);
        p_rd++;
        r_words++;
      end else begin
        rd_rsp_valid = 1'b0;
      end
      rd_req_ready = r_ready_en;
      if (rd_req_valid && rd_req_ready) begin
        chk(rd_req_addr == r_exp_addr, "R3", "read burst address", rd_req_addr, r_exp_addr);
        chk(int'(rd_req_addr[5:3]) + int'(rd_req_words) <= 8, "R3", "read burst crosses 64B",
            rd_req_addr, rd_req_words);
        for (int k = 0; k < int'(rd_req_words); k++) begin
          pend[p_wr % 256] = r_exp_addr;
          p_wr++;
          r_exp_addr += 32'd8;
        end
        r_bursts++;
      end
      wr_req_ready = w_ready_en;
      if (wr_req_valid && wr_req_ready) begin
        chk(wr_req_addr == w_exp_addr, "R6", "write word address", wr_req_addr, w_exp_addr);
        chk(wr_req_be == exp_be(w_exp_addr), "R7", "byte enables", wr_req_be, exp_be(w_exp_addr));
        chk(wr_req_data == upat(int'((w_exp_addr - w_base) >> 3)), "R6", "write data",
            wr_req_data, upat(int'((w_exp_addr - w_base) >> 3)));
        if (wr_req_last) w_bursts++;
        w_words++;
        w_exp_addr += 32'd8;
      end
      usr_in_valid = u_en && (u_fed < u_total);
      usr_in_data  = upat(u_fed);
      if (usr_in_valid && usr_in_ready) u_fed++;
      #1;
      if (rd_rsp_valid)
        chk(usr_out_valid && usr_out_data == rpat(cur_rsp), "R4", "user stream word",
            usr_out_data, rpat(cur_rsp));
    end
  end

  task automatic send_cmd(input bit dir, input logic [31:0] a, input logic [15:0] l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dir = dir; cmd_addr = a; cmd_len = l;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy[dir] && !done[dir], "R1", "busy after accepted command", {busy, done}, 4'b0);
  endtask

  task automatic wait_done(input int ch);
    int t = 0;
    while (!done[ch] && t < 5000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  task automatic setup_rd(input logic [31:0] a);
    r_exp_addr = {a[31:3], 3'b000};
    r_bursts = 0; r_words = 0; dp_cnt[0] = 0;
  endtask

  task automatic setup_wr(input logic [31:0] a, input logic [15:0] l);
    w_exp_addr = {a[31:3], 3'b000}; w_base = w_exp_addr;
    w_lo = a; w_hi = a + 32'(l);
    w_bursts = 0; w_words = 0; u_fed = 0; u_total = tot_words(a, l); u_en = 1'b1;
    dp_cnt[1] = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_dir = 1'b0; cmd_addr = '0; cmd_len = '0;
    dp_cnt[0] = 0; dp_cnt[1] = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(busy == 2'b00 && done == 2'b00 && done_pulse == 2'b00, "R12", "status in reset",
        {busy, done, done_pulse}, 0);
    chk(!rd_req_valid && !wr_req_valid && !usr_in_ready, "R12", "requests in reset",
        {rd_req_valid, wr_req_valid, usr_in_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: each entry as a read and as a write
    for (int i = 0; i < 6; i++) begin
      setup_rd(VEC[i].addr);
      send_cmd(1'b0, VEC[i].addr, VEC[i].len);
      wait_done(0);
      chk(r_bursts == int'(VEC[i].bursts), "R3", "read burst count", r_bursts, VEC[i].bursts);
      chk(r_words == tot_words(VEC[i].addr, VEC[i].len), "R5", "read words returned",
          r_words, tot_words(VEC[i].addr, VEC[i].len));
      chk(dp_cnt[0] == 1 && !busy[0] && done[0], "R5", "read completion pulse", dp_cnt[0], 1);

      setup_wr(VEC[i].addr, VEC[i].len);
      send_cmd(1'b1, VEC[i].addr, VEC[i].len);
      wait_done(1);
      u_en = 1'b0;
      chk(w_bursts == int'(VEC[i].bursts), "R6", "write burst count", w_bursts, VEC[i].bursts);
      chk(w_words == u_total && u_fed == u_total, "R9", "write words accepted", w_words, u_total);
      chk(dp_cnt[1] == 1 && !busy[1] && done[1], "R9", "write completion pulse", dp_cnt[1], 1);
    end

    // R2 and R11: command during busy is ignored, stalled request holds
    r_ready_en = 1'b0;
    setup_rd(32'h5000);
    send_cmd(1'b0, 32'h5000, 16'd128);
    send_cmd(1'b0, 32'h9000, 16'd8);
    repeat (5) @(negedge clk);
    chk(rd_req_valid && rd_req_addr == 32'h5000 && rd_req_words == 4'd8, "R11",
        "stalled read request", rd_req_addr, 32'h5000);
    r_ready_en = 1'b1;
    wait_done(0);
    chk(r_bursts == 2 && r_words == 16, "R2", "ignored command left transfer intact",
        r_words, 16);
    repeat (3) @(negedge clk);
    chk(!busy[0] && !rd_req_valid && r_bursts == 2, "R2", "no second transfer", r_bursts, 2);

    // R8: double buffer fills two bursts while the host stalls
    w_ready_en = 1'b0;
    setup_wr(32'h6000, 16'd256);
    send_cmd(1'b1, 32'h6000, 16'd256);
    repeat (40) @(negedge clk);
    chk(u_fed == 16 && !usr_in_ready, "R8", "words buffered while stalled", u_fed, 16);
    chk(wr_req_valid && wr_req_addr == 32'h6000, "R11", "stalled write request",
        wr_req_addr, 32'h6000);
    w_ready_en = 1'b1;
    wait_done(1);
    u_en = 1'b0;
    chk(w_words == 32 && w_bursts == 4, "R8", "all buffered bursts written", w_words, 32);

    // R10: read and write concurrently
    setup_rd(32'h8000);
    setup_wr(32'h7008, 16'd120);
    send_cmd(1'b0, 32'h8000, 16'd64);
    send_cmd(1'b1, 32'h7008, 16'd120);
    chk(busy == 2'b11, "R10", "both channels busy", busy, 2'b11);
    wait_done(0);
    wait_done(1);
    u_en = 1'b0;
    chk(r_words == 8 && done[0], "R10", "concurrent read finished", r_words, 8);
    chk(w_words == 15 && w_bursts == 2 && done[1], "R10", "concurrent write finished",
        w_words, 15);

    finish_run();
  end
endmodule